// File: doc/BRIEF.md
# Triggered Snapshot Spy Buffer

This block watches a stream of trigger-primitive words, one word for each bunch crossing. When a trigger-accept pulse arrives, it records a window of seven consecutive crossings into an internal buffer. Every stored word carries the sequence number of the trigger that caused the capture, so a reader can match each snapshot to its event. The sequence counter advances on every trigger pulse, including pulses that are not stored.

The buffer holds a whole number of snapshots. When the last word of the final snapshot is written, capture freezes and a full flag rises. The host then drains the buffer in capture order, one word per read strobe. Reading the final word re-arms recording, and so does a clear pulse at any time. A trigger that arrives while a window is still being captured is not stored; it is counted in a saturating dropped-trigger counter instead.

The controller is a three-state machine:

- ST_ARMED waits for a trigger.
- ST_CAPTURE writes the window.
- ST_FROZEN holds the full buffer for readout.

The named transitions are:

- ARM_TO_CAP: a trigger arrives without a clear.
- CAP_TO_ARM: the last slot of the window is written and room remains, or a clear arrives.
- CAP_TO_FROZEN: the last slot of the final snapshot is written.
- FROZEN_TO_ARM: a clear arrives, or the final word is read.

A parameter sets a pre-trigger offset, which is the number of crossings the window starts before the trigger. Its default is 0.

Top module: `spy_buffer`

## Requirements
- R1: A trigger accepted in ST_ARMED stores the data word of the crossing on which the pulse is sampled (with the default offset of 0), followed by the next six crossings, into consecutive buffer slots.
- R2: Every word of a snapshot carries the same tag. The tag is the count, modulo 2^SEQ_W, of trigger pulses seen since reset before the accepted one. Dropped, ignored and clear-cycle pulses all count.
- R3: A trigger sampled on any of the six crossings after an accepted trigger is not stored, and drop_count rises by one, saturating at its maximum.
- R4: full rises on the cycle after the seventh word of the final (NSNAP-th) snapshot is written. While full is high, triggers store nothing and leave drop_count unchanged.
- R5: Each read strobe returns the oldest unread word one cycle later, with rd_valid=1. A strobe with no unread word returns rd_valid=0, and rd_seq and rd_data are both zero. rd_valid is 0 in any cycle not preceded by a strobe.
- R6: Reading the final word (index NSNAP*7-1) while full re-arms the buffer: full falls, and the next trigger is stored at slot 0.
- R7: A clear pulse discards all stored words, resets both pointers and the full flag, and takes priority over a trigger in the same cycle, so that trigger is not stored.
- R8: After reset, full=0, rd_valid=0, drop_count=0, and the sequence count starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_data | input | DATA_W | Primitive word of the current crossing |
| trig | input | 1 | Trigger-accept pulse |
| clr | input | 1 | Re-arm pulse; discards the buffer contents |
| rd_stb | input | 1 | Read strobe, one word per pulse |
| rd_valid | output | 1 | Returned word is a stored record |
| rd_seq | output | SEQ_W | Trigger tag of the returned word |
| rd_data | output | DATA_W | Data of the returned word |
| full | output | 1 | Buffer frozen and awaiting readout |
| drop_count | output | DROP_W | Triggers lost during a capture window |

## Verification
The assertions assume that clr and rd_stb are never asserted in the same cycle. They also assume that rd_stb and clr are single-cycle controls driven only after reset is released, so a falling full flag can be traced to one of them. The stimulus keeps these controls apart, with one exception: a clear is deliberately paired with a trigger to exercise the priority rule. Triggers are placed at chosen offsets inside a capture window, on its final slot, and exactly seven crossings apart. Triggers are also sent while the buffer is frozen, so both the drop rule and the freeze rule are exercised.

// File: rtl/spy_pkg.sv
`timescale 1ns/1ps
package spy_pkg;
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_FROZEN  = 2'd2
    } spy_state_e;
endpackage

// File: rtl/spy_delay.sv
`timescale 1ns/1ps
module spy_delay #(
    parameter int DATA_W  = 16,
    parameter int PRE_DLY = 0
) (
    input  logic              clk,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    generate
        if (PRE_DLY == 0) begin : g_pass
            assign dout = din;
        end else begin : g_line
            logic [DATA_W-1:0] stage [PRE_DLY];
            always_ff @(posedge clk) begin
                stage[0] <= din;
                for (int i = 1; i < PRE_DLY; i++) begin
                    stage[i] <= stage[i-1];
                end
            end
            assign dout = stage[PRE_DLY-1];
        end
    endgenerate
endmodule

// File: rtl/spy_ctrl.sv
`timescale 1ns/1ps
module spy_ctrl
    import spy_pkg::*;
#(
    parameter int WIN    = 7,
    parameter int NSNAP  = 16,
    parameter int SEQ_W  = 8,
    parameter int DROP_W = 8,
    localparam int DEPTH  = WIN * NSNAP,
    localparam int PTR_W  = $clog2(DEPTH + 1),
    localparam int AW     = $clog2(DEPTH),
    localparam int SLOT_W = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              clr,
    input  logic              rd_stb,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [SEQ_W-1:0]  wr_seq,
    output logic              rd_hit,
    output logic [AW-1:0]     rd_addr,
    output logic              full,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [DROP_W-1:0] DROP_MAX = '1;

    spy_state_e        state, state_nxt;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [SLOT_W-1:0] slot;
    logic [SEQ_W-1:0]  seq_ctr, cur_seq;
    logic [DROP_W-1:0] drop_ctr;
    logic              last_slot, last_snap, final_rd, rearm;

    assign last_slot = (slot == SLOT_W'(WIN - 1));
    assign last_snap = (wr_ptr == PTR_W'(DEPTH - 1));
    assign rd_hit    = (rd_ptr < wr_ptr);
    assign final_rd  = (state == ST_FROZEN) && rd_stb && rd_hit
                       && (rd_ptr == PTR_W'(DEPTH - 1));
    assign rearm     = clr || final_rd;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ARMED;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ARMED: begin
                if (trig && !clr) state_nxt = ST_CAPTURE;              // ARM_TO_CAP
            end
            ST_CAPTURE: begin
                if (clr)            state_nxt = ST_ARMED;              // CAP_TO_ARM
                else if (last_slot) state_nxt = last_snap ? ST_FROZEN  // CAP_TO_FROZEN
                                                          : ST_ARMED;  // CAP_TO_ARM
            end
            ST_FROZEN: begin
                if (rearm) state_nxt = ST_ARMED;                       // FROZEN_TO_ARM
            end
            default: state_nxt = ST_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        wr_en = 1'b0;
        wr_seq = cur_seq;
        full = 1'b0;
        unique case (state)
            ST_ARMED: begin
                wr_en  = trig && !clr;
                wr_seq = seq_ctr;
            end
            ST_CAPTURE: wr_en = !clr;
            ST_FROZEN:  full  = 1'b1;
            default: ;
        endcase
    end

    assign wr_addr    = wr_ptr[AW-1:0];
    assign rd_addr    = rd_ptr[AW-1:0];
    assign drop_count = drop_ctr;

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            slot     <= '0;
            seq_ctr  <= '0;
            cur_seq  <= '0;
            drop_ctr <= '0;
        end else begin
            if (trig) seq_ctr <= seq_ctr + 1'b1;
            if (state == ST_ARMED && trig && !clr) cur_seq <= seq_ctr;

            if (clr) begin
                slot <= '0;
            end else if (state == ST_ARMED && trig) begin
                slot <= SLOT_W'(1);
            end else if (state == ST_CAPTURE) begin
                slot <= last_slot ? '0 : slot + 1'b1;
            end

            if (rearm) begin
                wr_ptr <= '0;
            end else if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
            end

            if (rearm) begin
                rd_ptr <= '0;
            end else if (rd_stb && rd_hit) begin
                rd_ptr <= rd_ptr + 1'b1;
            end

            if (state == ST_CAPTURE && trig && !clr && drop_ctr != DROP_MAX) begin
                drop_ctr <= drop_ctr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spy_store.sv
`timescale 1ns/1ps
module spy_store #(
    parameter int DATA_W = 16,
    parameter int SEQ_W  = 8,
    parameter int DEPTH  = 112,
    localparam int AW    = $clog2(DEPTH),
    localparam int REC_W = SEQ_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [SEQ_W-1:0]  wr_seq,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              rd_hit,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [SEQ_W-1:0]  rd_seq,
    output logic [DATA_W-1:0] rd_data
);
    logic [REC_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= {wr_seq, wr_data};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_seq   <= '0;
            rd_data  <= '0;
        end else if (rd_stb && rd_hit) begin
            rd_valid <= 1'b1;
            {rd_seq, rd_data} <= mem[rd_addr];
        end else begin
            rd_valid <= 1'b0;
            rd_seq   <= '0;
            rd_data  <= '0;
        end
    end
endmodule

// File: rtl/spy_buffer.sv
`timescale 1ns/1ps
module spy_buffer #(
    parameter int DATA_W  = 16,
    parameter int WIN     = 7,
    parameter int NSNAP   = 16,
    parameter int PRE_DLY = 0,
    parameter int SEQ_W   = 8,
    parameter int DROP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bx_data,
    input  logic              trig,
    input  logic              clr,
    input  logic              rd_stb,
    output logic              rd_valid,
    output logic [SEQ_W-1:0]  rd_seq,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic [DROP_W-1:0] drop_count
);
    localparam int DEPTH = WIN * NSNAP;
    localparam int AW    = $clog2(DEPTH);

    logic [DATA_W-1:0] cap_data;
    logic              wr_en, rd_hit;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [SEQ_W-1:0]  wr_seq;

    spy_delay #(.DATA_W(DATA_W), .PRE_DLY(PRE_DLY)) u_delay (
        .clk (clk),
        .din (bx_data),
        .dout(cap_data)
    );

    spy_ctrl #(.WIN(WIN), .NSNAP(NSNAP), .SEQ_W(SEQ_W), .DROP_W(DROP_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .clr       (clr),
        .rd_stb    (rd_stb),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_seq    (wr_seq),
        .rd_hit    (rd_hit),
        .rd_addr   (rd_addr),
        .full      (full),
        .drop_count(drop_count)
    );

    spy_store #(.DATA_W(DATA_W), .SEQ_W(SEQ_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_seq  (wr_seq),
        .wr_data (cap_data),
        .rd_stb  (rd_stb),
        .rd_hit  (rd_hit),
        .rd_addr (rd_addr),
        .rd_valid(rd_valid),
        .rd_seq  (rd_seq),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/spy_buffer_chk.sv
`timescale 1ns/1ps
module spy_buffer_chk #(
    parameter int DROP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic              clr,
    input logic              rd_stb,
    input logic              rd_valid,
    input logic              full,
    input logic [DROP_W-1:0] drop_count
);
    AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        full && !clr && !rd_stb |=> full);                                  // R4
    AST_FROZEN_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        full && trig |=> $stable(drop_count));                              // R4
    AST_DROP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop_count < $past(drop_count)));                                 // R3
    AST_RD_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_stb));                                        // R5
    AST_FULL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> ($past(clr) || $past(rd_stb)));                     // R6
    AST_CLR_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !full);                                                     // R7
endmodule

bind spy_buffer spy_buffer_chk #(.DROP_W(DROP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .clr       (clr),
    .rd_stb    (rd_stb),
    .rd_valid  (rd_valid),
    .full      (full),
    .drop_count(drop_count)
);

// File: tb/spy_buffer_bench.sv
`timescale 1ns/1ps
module spy_buffer_bench;
    localparam int DATA_W = 16;
    localparam int SEQ_W  = 8;
    localparam int DROP_W = 8;
    localparam int WIN    = 7;
    localparam int NSNAP  = 16;
    localparam int DEPTH  = WIN * NSNAP;
    localparam int REC_W  = SEQ_W + DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] bx_data = '0;
    logic              trig = 1'b0, clr = 1'b0, rd_stb = 1'b0;
    logic              rd_valid, full;
    logic [SEQ_W-1:0]  rd_seq;
    logic [DATA_W-1:0] rd_data;
    logic [DROP_W-1:0] drop_count;

    always #2 clk = ~clk;

    spy_buffer u_spy_buffer (
        .clk(clk), .rst_n(rst_n), .bx_data(bx_data), .trig(trig), .clr(clr),
        .rd_stb(rd_stb), .rd_valid(rd_valid), .rd_seq(rd_seq), .rd_data(rd_data),
        .full(full), .drop_count(drop_count)
    );

    int n_tests = 0, n_fail = 0;
    bit mon_on = 0;

    // Reference model state (from the requirements)
    logic [REC_W-1:0] store_q [$];
    logic [REC_W:0]   rexp_q  [$];
    int               slot = 0, rd_idx = 0, drop = 0, data_ctr = 0;
    logic [SEQ_W-1:0] seq = '0, cur_seq = '0;
    bit               frozen = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one crossing of stimulus plus the model update for the coming edge
    task automatic step(input bit t, input bit c, input bit r);
        bit rearm;
        @(negedge clk);
        trig = t; clr = c; rd_stb = r;
        bx_data = DATA_W'(data_ctr * 37 + 11);
        data_ctr++;
        rearm = 0;
        if (c) begin
            store_q.delete(); rd_idx = 0; slot = 0; frozen = 0;
        end else begin
            if (r) begin
                if (rd_idx < store_q.size()) begin
                    rexp_q.push_back({1'b1, store_q[rd_idx]});
                    rd_idx++;
                    if (frozen && rd_idx == DEPTH) rearm = 1;
                end else begin
                    rexp_q.push_back('0);
                end
            end
            if (frozen) begin
            end else if (slot > 0) begin
                store_q.push_back({cur_seq, bx_data});
                if (t && drop < 255) drop++;
                slot++;
                if (slot == WIN) begin
                    slot = 0;
                    if (store_q.size() == DEPTH) frozen = 1;
                end
            end else if (t) begin
                cur_seq = seq;
                store_q.push_back({cur_seq, bx_data});
                slot = 1;
            end
            if (rearm) begin
                store_q.delete(); rd_idx = 0; frozen = 0;
            end
        end
        if (t) seq++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic reads(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1);
    endtask

    task automatic snapshot();
        step(1, 0, 0);
        idle(WIN - 1);
    endtask

    // Monitor: pops scoreboard entries as read results appear
    always @(posedge clk) begin
        bit r;
        logic [REC_W:0] e;
        r = rd_stb;
        #1;
        if (mon_on) begin
            if (r) begin
                if (rexp_q.size() == 0) begin
                    chk(0, "R5 unexpected read", 1, 0);
                end else begin
                    e = rexp_q.pop_front();
                    chk(rd_valid == e[REC_W], "R5 rd_valid", int'(rd_valid), int'(e[REC_W]));
                    chk(rd_data == e[DATA_W-1:0], "R1 rd_data", int'(rd_data), int'(e[DATA_W-1:0]));
                    chk(rd_seq == e[REC_W-1:DATA_W], "R2 rd_seq", int'(rd_seq), int'(e[REC_W-1:DATA_W]));
                end
            end else begin
                chk(rd_valid == 1'b0, "R5 no strobe", int'(rd_valid), 0);
            end
            chk(full == frozen, "R4 full", int'(full), int'(frozen));
            chk(int'(drop_count) == drop, "R3 drop_count", int'(drop_count), drop);
        end
    end

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(full == 1'b0, "R8 reset full", int'(full), 0);
        chk(rd_valid == 1'b0, "R8 reset rd_valid", int'(rd_valid), 0);
        chk(drop_count == '0, "R8 reset drop_count", int'(drop_count), 0);
        mon_on = 1;

        // R1/R2/R5: one snapshot, read it back plus one empty read
        snapshot();
        idle(3);
        reads(WIN + 1);

        // R3: triggers inside a window (mid and last slot), then back-to-back
        step(1, 0, 0); idle(2); step(1, 0, 0); idle(2); step(1, 0, 0);
        step(1, 0, 0); idle(WIN - 1);
        idle(2);
        reads(2 * WIN + 1);

        // R7: clear discards a captured snapshot; clear beats a trigger
        snapshot();
        step(0, 1, 0);
        idle(1);
        reads(1);
        step(1, 1, 0);
        idle(WIN + 1);
        reads(1);
        chk(rd_valid == 1'b0, "R7 cleared read", int'(rd_valid), 0);

        // R4: fill all snapshots, then triggers while frozen are ignored
        for (int i = 0; i < NSNAP; i++) begin
            snapshot();
            idle(2);
        end
        step(1, 0, 0); idle(3); step(1, 0, 0); idle(3);
        chk(full == 1'b1, "R4 frozen", int'(full), 1);

        // R6: drain everything; final read re-arms
        reads(DEPTH);
        idle(1);
        chk(full == 1'b0, "R6 rearm", int'(full), 0);
        snapshot();
        idle(1);
        reads(WIN + 1);

        // R7: fill again, then clear from the frozen state
        for (int i = 0; i < NSNAP; i++) snapshot();
        idle(2);
        step(0, 1, 0);
        idle(1);
        chk(full == 1'b0, "R7 clear exits freeze", int'(full), 1'b0);
        reads(1);
        idle(3);
        chk(rexp_q.size() == 0, "R5 scoreboard drained", rexp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule